// File: doc/BRIEF.md
# Reset Configuration Word Fetcher

At the end of a hard reset this block acts as the configuration master. It reads a table of single bytes from the boot memory through a request/acknowledge read port. Only the lowest data lane is sampled, so the width of the boot device does not matter. The bytes are packed into 32-bit configuration words: the first word belongs to the master and the next seven to slave devices.

When the table has been read, the block raises `done`. It shows its own word and derives the reset fetch address from a prefix bit in that word: offset 0x100 from a low base (0x00000000) or a high base (0xFFF00000). The slave words are read through an indexed combinational port. Once a new hard reset is applied, the fetch runs again from the beginning.

Top module: `rcfg_fetch_top`

## Requirements
- R1: The first read request after reset carries address 0. Each accepted read moves the next request's address up by 8.
- R2: Exactly 32 reads are accepted per reset. No request is raised once `done` is high.
- R3: Only bits 7:0 of `mem_rdata` are captured on an accepted read. All higher bits are ignored.
- R4: Reads 4k..4k+3 form word k, with read 4k in bits 31:24 and read 4k+3 in bits 7:0.
- R5: Word 0 appears on `master_word`. For `slv_idx` = n with n in 1..7, `slv_word` returns word n once `done` is high.
- R6: With `done` high, `reset_addr` is 0x00000100 when bit 0 of the master word is 0, and 0xFFF00100 when that bit is 1.
- R7: A request holds high with an unchanged address until the cycle in which `mem_ack` is seen. Only one read is outstanding at a time, and any number of wait cycles is allowed.
- R8: `done` rises at the clock edge after the one that captures the 32nd byte. It then stays high, and `master_word` and `reset_addr` stay stable until the next reset.
- R9: `slv_idx` = 0 returns `slv_word` = 0 and raises `slv_bad`.
- R10: While `done` is low, including during reset, `master_word`, `reset_addr` and `slv_word` read 0 and `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hard reset |
| mem_req | output | 1 | Read request to boot memory |
| mem_addr | output | 32 | Byte address of the pending read |
| mem_ack | input | 1 | Read accepted; data valid this cycle |
| mem_rdata | input | 64 | Read data; only bits 7:0 used |
| done | output | 1 | Configuration fetch complete |
| master_word | output | 32 | Master's own configuration word |
| reset_addr | output | 32 | Reset fetch address |
| slv_idx | input | 3 | Slave word index (1..7) |
| slv_word | output | 32 | Selected slave word |
| slv_bad | output | 1 | Index is not a slave index |

## Verification
A byte is captured at the edge that sees `mem_ack`. The next request address appears after that same edge, so the bench model checks each address at the falling edge at which it raises acknowledge. `done` is due exactly one edge after the last capture. The bench records the cycle count at the 32nd capture and compares it with the count at which `done` is first seen. The slave port is combinational and is sampled one nanosecond after the index changes. All outputs are read at falling edges, away from the edge that updates them.

// File: rtl/rcfg_pkg.sv
package rcfg_pkg;
    typedef enum logic [1:0] {
        SEQ_START = 2'd0,
        SEQ_FETCH = 2'd1,
        SEQ_LAST  = 2'd2,
        SEQ_DONE  = 2'd3
    } seq_st_e;
endpackage

// File: rtl/rcfg_seq.sv
module rcfg_seq #(
    parameter int ADDR_W  = 32,
    parameter int N_READS = 32,
    parameter int STRIDE  = 8,
    localparam int IDX_W  = $clog2(N_READS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mem_ack,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              cap_en,
    output logic [IDX_W-1:0]  cap_idx,
    output logic              done
);
    import rcfg_pkg::*;

    localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(STRIDE);
    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(N_READS - 1);

    typedef struct packed {
        seq_st_e           st;
        logic [IDX_W-1:0]  cnt;
        logic [ADDR_W-1:0] addr;
    } seq_s;

    seq_s q, d;

    always_comb begin
        d      = q;
        cap_en = (q.st == SEQ_FETCH) && mem_ack;
        unique case (q.st)
            SEQ_START: d.st = SEQ_FETCH;
            SEQ_FETCH: begin
                if (mem_ack) begin
                    d.cnt  = q.cnt + 1'b1;
                    d.addr = q.addr + STEP;
                    if (q.cnt == LAST_IDX) d.st = SEQ_LAST;
                end
            end
            SEQ_LAST:  d.st = SEQ_DONE;
            SEQ_DONE:  d.st = SEQ_DONE;
            default:   d.st = SEQ_START;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st   <= SEQ_START;
            q.cnt  <= '0;
            q.addr <= '0;
        end else begin
            q <= d;
        end
    end

    assign mem_req  = (q.st == SEQ_FETCH);
    assign mem_addr = q.addr;
    assign cap_idx  = q.cnt;
    assign done     = (q.st == SEQ_DONE);
endmodule

// File: rtl/rcfg_store.sv
module rcfg_store #(
    parameter int N_WORDS    = 8,
    parameter int WORD_BYTES = 4,
    localparam int N_READS   = N_WORDS * WORD_BYTES,
    localparam int IDX_W     = $clog2(N_READS),
    localparam int BSEL_W    = $clog2(WORD_BYTES),
    localparam int WSEL_W    = IDX_W - BSEL_W,
    localparam int WORD_W    = 8 * WORD_BYTES
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            cap_en,
    input  logic [IDX_W-1:0]                cap_idx,
    input  logic [7:0]                      lane_in,
    output logic [N_WORDS-1:0][WORD_W-1:0]  words
);
    logic [BSEL_W-1:0] byte_sel;
    logic [WSEL_W-1:0] word_sel;

    assign byte_sel = cap_idx[BSEL_W-1:0];
    assign word_sel = cap_idx[IDX_W-1:BSEL_W];

    for (genvar g = 0; g < N_WORDS; g++) begin : g_word
        logic [WORD_W-1:0] word_d, word_q;

        always_comb begin
            word_d = word_q;
            if (cap_en && (word_sel == WSEL_W'(g))) begin
                // earliest byte of a group lands in the top byte
                word_d[(WORD_BYTES - 1 - int'(byte_sel)) * 8 +: 8] = lane_in;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) word_q <= '0;
            else        word_q <= word_d;
        end

        assign words[g] = word_q;
    end
endmodule

// File: rtl/rcfg_slave_port.sv
module rcfg_slave_port #(
    parameter int N_WORDS = 8,
    parameter int WORD_W  = 32,
    localparam int SEL_W  = $clog2(N_WORDS)
) (
    input  logic                            done,
    input  logic [SEL_W-1:0]                idx,
    input  logic [N_WORDS-1:0][WORD_W-1:0]  words,
    output logic [WORD_W-1:0]               word_out,
    output logic                            bad
);
    if (N_WORDS == (1 << SEL_W)) begin : g_full
        assign bad = (idx == '0);
    end else begin : g_part
        assign bad = (idx == '0) || (idx >= SEL_W'(N_WORDS));
    end

    always_comb begin
        word_out = '0;
        if (done && !bad) word_out = words[idx];
    end
endmodule

// File: rtl/rcfg_fetch_top.sv
module rcfg_fetch_top #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 64,
    parameter int N_WORDS    = 8,
    parameter int WORD_BYTES = 4,
    parameter int STRIDE     = 8,
    parameter int PREFIX_BIT = 0,
    parameter logic [ADDR_W-1:0] LOW_BASE  = 32'h0000_0000,
    parameter logic [ADDR_W-1:0] HIGH_BASE = 32'hFFF0_0000,
    parameter logic [ADDR_W-1:0] VEC_OFF   = 32'h0000_0100,
    localparam int N_READS   = N_WORDS * WORD_BYTES,
    localparam int IDX_W     = $clog2(N_READS),
    localparam int WORD_W    = 8 * WORD_BYTES,
    localparam int SEL_W     = $clog2(N_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic [WORD_W-1:0] master_word,
    output logic [ADDR_W-1:0] reset_addr,
    input  logic [SEL_W-1:0]  slv_idx,
    output logic [WORD_W-1:0] slv_word,
    output logic              slv_bad
);
    logic                           cap_en;
    logic [IDX_W-1:0]               cap_idx;
    logic [N_WORDS-1:0][WORD_W-1:0] words;
    logic                           unused_hi_lanes;

    assign unused_hi_lanes = ^mem_rdata[DATA_W-1:8];

    rcfg_seq #(
        .ADDR_W (ADDR_W),
        .N_READS(N_READS),
        .STRIDE (STRIDE)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .mem_ack (mem_ack),
        .mem_req (mem_req),
        .mem_addr(mem_addr),
        .cap_en  (cap_en),
        .cap_idx (cap_idx),
        .done    (done)
    );

    rcfg_store #(
        .N_WORDS   (N_WORDS),
        .WORD_BYTES(WORD_BYTES)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (cap_en),
        .cap_idx(cap_idx),
        .lane_in(mem_rdata[7:0]),
        .words  (words)
    );

    rcfg_slave_port #(
        .N_WORDS(N_WORDS),
        .WORD_W (WORD_W)
    ) u_port (
        .done    (done),
        .idx     (slv_idx),
        .words   (words),
        .word_out(slv_word),
        .bad     (slv_bad)
    );

    always_comb begin
        master_word = '0;
        reset_addr  = '0;
        if (done) begin
            master_word = words[0];
            reset_addr  = (words[0][PREFIX_BIT] ? HIGH_BASE : LOW_BASE) + VEC_OFF;
        end
    end
endmodule

// File: rtl/rcfg_fetch_chk.sv
module rcfg_fetch_chk #(
    parameter int ADDR_W     = 32,
    parameter int N_READS    = 32,
    parameter int STRIDE     = 8,
    parameter int WORD_W     = 32,
    parameter int SEL_W      = 3,
    parameter int PREFIX_BIT = 0,
    parameter logic [ADDR_W-1:0] LOW_BASE  = 32'h0000_0000,
    parameter logic [ADDR_W-1:0] HIGH_BASE = 32'hFFF0_0000,
    parameter logic [ADDR_W-1:0] VEC_OFF   = 32'h0000_0100,
    localparam int CNT_W = $clog2(N_READS + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_ack,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              done,
    input logic [WORD_W-1:0] master_word,
    input logic [ADDR_W-1:0] reset_addr,
    input logic [SEL_W-1:0]  slv_idx,
    input logic [WORD_W-1:0] slv_word,
    input logic              slv_bad
);
    logic [CNT_W-1:0] acc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   acc_q <= '0;
        else if (mem_req && mem_ack && acc_q != '1)   acc_q <= acc_q + 1'b1;
    end

    // R1
    first_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && acc_q == '0) |-> mem_addr == '0);

    // R1
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && acc_q < CNT_W'(N_READS - 1))
        |=> (mem_req && mem_addr == $past(mem_addr) + ADDR_W'(STRIDE)));

    // R2
    read_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (acc_q == CNT_W'(N_READS) && !mem_req));

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    // R8
    done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(mem_req && mem_ack, 2));

    // R8
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (done && $stable(master_word) && $stable(reset_addr)));

    // R6
    vec_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> reset_addr == ((master_word[PREFIX_BIT] ? HIGH_BASE : LOW_BASE) + VEC_OFF));

    // R9
    bad_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (slv_idx == '0) |-> (slv_bad && slv_word == '0));

    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (master_word == '0 && reset_addr == '0 && slv_word == '0));
endmodule

bind rcfg_fetch_top rcfg_fetch_chk #(
    .ADDR_W    (ADDR_W),
    .N_READS   (N_READS),
    .STRIDE    (STRIDE),
    .WORD_W    (WORD_W),
    .SEL_W     (SEL_W),
    .PREFIX_BIT(PREFIX_BIT),
    .LOW_BASE  (LOW_BASE),
    .HIGH_BASE (HIGH_BASE),
    .VEC_OFF   (VEC_OFF)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req    (mem_req),
    .mem_ack    (mem_ack),
    .mem_addr   (mem_addr),
    .done       (done),
    .master_word(master_word),
    .reset_addr (reset_addr),
    .slv_idx    (slv_idx),
    .slv_word   (slv_word),
    .slv_bad    (slv_bad)
);

// File: tb/tb_rcfg_fetch_top.sv
`timescale 1ns/1ps
module tb_rcfg_fetch_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        done;
    logic [31:0] master_word;
    logic [31:0] reset_addr;
    logic [2:0]  slv_idx = 3'd0;
    logic [31:0] slv_word;
    logic        slv_bad;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // memory model settings
    logic [7:0] seed = 8'd0;
    int wbase = 0;
    int wadd = 0;
    int wcnt = 0;
    int nacks = 0;
    bit addr_bad = 0;
    int last_cap_cyc = 0;

    rcfg_fetch_top dut (
        .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done),
        .master_word(master_word), .reset_addr(reset_addr),
        .slv_idx(slv_idx), .slv_word(slv_word), .slv_bad(slv_bad)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [7:0] mbyte(logic [7:0] s, int n);
        logic [7:0] nb = 8'(n);
        return (nb * 8'd37 + s) ^ {nb[2:0], 5'b0};
    endfunction

    function automatic logic [31:0] exp_word(logic [7:0] s, int w);
        return {mbyte(s, 4*w), mbyte(s, 4*w+1), mbyte(s, 4*w+2), mbyte(s, 4*w+3)};
    endfunction

    task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // boot memory: ack after a wait, junk on all lanes but the lowest
    always @(negedge clk) begin
        if (!rst_n) begin
            mem_ack = 1'b0; wcnt = 0; nacks = 0; addr_bad = 0;
        end else begin
            if (mem_ack) begin
                mem_ack = 1'b0;
                nacks++;
                wcnt = 0;
                if (nacks == 32) last_cap_cyc = cyc;
            end
            if (mem_req) begin
                if (nacks >= 32) addr_bad = 1;
                else if (wcnt >= wbase + ((nacks % 2 == 1) ? wadd : 0)) begin
                    if (mem_addr != 32'(nacks * 8)) addr_bad = 1;
                    mem_ack = 1'b1;
                    mem_rdata = {{7{~mbyte(seed, nacks) ^ 8'h5A}}, mbyte(seed, nacks)};
                end else begin
                    wcnt++;
                end
            end
        end
    end

    // {seed, wbase, wadd}
    localparam logic [15:0] SCEN [6] = '{
        16'h3A_00, 16'h15_10, 16'h80_23, 16'hC7_31, 16'h04_52, 16'hFF_07
    };

    task automatic run_boot(logic [7:0] s, int wb, int wa, string tag);
        int done_cyc = -1;
        seed = s; wbase = wb; wadd = wa;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 3000 && done_cyc < 0; i++) begin
            @(negedge clk);
            if (done) done_cyc = cyc;
        end
        // R8: done one edge after the 32nd capture
        chk(done_cyc == last_cap_cyc + 1, {"R8 done timing ", tag}, 32'(done_cyc), 32'(last_cap_cyc + 1));
        // R1 R7: address sequence seen by the memory
        chk(!addr_bad, {"R1 address sequence ", tag}, 32'(addr_bad), 32'd0);
        // R3 R4: master word assembly from lowest lane, first byte on top
        chk(master_word == exp_word(s, 0), {"R4 master word ", tag}, master_word, exp_word(s, 0));
        // R6
        chk(reset_addr == (exp_word(s, 0)[0] ? 32'hFFF0_0100 : 32'h0000_0100),
            {"R6 reset address ", tag}, reset_addr,
            exp_word(s, 0)[0] ? 32'hFFF0_0100 : 32'h0000_0100);
        // R5
        for (int n = 1; n < 8; n++) begin
            slv_idx = 3'(n);
            #1;
            chk(slv_word == exp_word(s, n) && !slv_bad, {"R5 slave word ", tag}, slv_word, exp_word(s, n));
        end
        // R9
        slv_idx = 3'd0;
        #1;
        chk(slv_word == 32'd0 && slv_bad, {"R9 index zero ", tag}, slv_word, 32'd0);
        // R2: no more reads, exact count
        repeat (20) @(negedge clk);
        chk(nacks == 32 && !mem_req && !addr_bad && done, {"R2 read count ", tag}, 32'(nacks), 32'd32);
    endtask

    initial begin
        // R10: reset state
        repeat (2) @(negedge clk);
        chk(!done && !mem_req && master_word == 0 && reset_addr == 0 && slv_word == 0,
            "R10 reset state", master_word | reset_addr, 32'd0);

        for (int k = 0; k < 6; k++) begin
            run_boot(SCEN[k][15:8], int'(SCEN[k][7:4]), int'(SCEN[k][3:0]), $sformatf("scen%0d", k));
        end

        // R10: outputs stay zero mid-sequence
        seed = 8'h22; wbase = 1; wadd = 0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        slv_idx = 3'd2;
        for (int i = 0; i < 500 && nacks < 12; i++) @(negedge clk);
        chk(!done && master_word == 0 && reset_addr == 0 && slv_word == 0,
            "R10 zero before done", master_word | reset_addr | slv_word, 32'd0);

        // R1: reset in mid-fetch restarts at address 0 and rebuilds words
        run_boot(8'h6D, 0, 2, "restart");

        // R3: lane junk differs per seed; prefix both ways covered above
        chk(exp_word(8'h3A, 0)[0] != exp_word(8'h15, 0)[0], "R3 R6 stimulus covers both prefixes",
            32'(exp_word(8'h3A, 0)[0]), 32'(~exp_word(8'h15, 0)[0]));

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%08h expected=%08h", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule